// File: doc/BRIEF.md
# OTP Shadow-Register Command Controller

This block sits on a byte-wide host stream where every byte carries a data/command qualifier, and it looks after a small one-time-programmable configuration matrix. The matrix is modelled as a row of shadow registers, which the rest of the chip reads, next to a behavioural non-volatile array that stands in for the fuse cells. The block recognises only the few commands that concern this matrix. Every other command code is accepted and dropped.

A calibration-control command, followed by one data byte, sets the calibration-mode flag, the programming-enable flag and the row address. A wake command starts a background refresh that copies the non-volatile array into the shadows after a fixed number of cycles. A shift command streams data bytes into the shadow chain, newest at position 0. Two further commands choose whether the effective configuration comes fully from the matrix, or from host-supplied settings apart from one calibration byte. A programming pulse input stands in for the external high-voltage pulse and writes one row into the array.

Top module: `otp_shadow_ctrl`

## Requirements
- R1: After reset, the shadow contents are all zero, the calibration-mode and programming-enable flags are 0, the row address is 0, busy is 0 and the factory-default select is 1.
- R2: Command 0xF0 (qualifier 0) arms a configuration load. The next data byte (qualifier 1) sets calibration mode from bit 0, programming enable from bit 1 and the row address from bits 4:2. Bits 7:5 are ignored.
- R3: The program-switch enable output equals the programming-enable flag.
- R4: Command 0x11, sent while calibration mode is 0, raises busy in the same cycle that captures it. Busy stays high for REFRESH_CYCLES cycles. In the cycle it falls, the shadows are loaded from the non-volatile array.
- R5: Command 0x11 sent while calibration mode is 1 starts no refresh. Busy stays 0 and the shadows are unchanged.
- R6: While a refresh runs, other commands are still decoded and take effect.
- R7: After command 0xF1, each data byte places its bits 6:0 in shadow byte 0, and byte i moves to byte i+1. The top byte is lost. Shadow byte i occupies bits 7i+6:7i of the flat output.
- R8: Any command byte ends shifting. Data bytes after that command do not shift.
- R9: A programming pulse changes the array only when calibration mode and programming enable are both 1. It then ORs shadow byte [row address] into array row [row address]. Array bits never return to 0.
- R10: Command 0xEE clears the factory-default select and 0xEF sets it. With the select at 1, the effective configuration equals the shadows. With it at 0, byte CAL_IDX comes from the shadows and every other byte comes from the host configuration input.
- R11: Data bytes with no armed command, and command codes other than the five above, change no output.
- R12: A second 0x11 that arrives during a refresh neither restarts nor extends it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | A byte is presented this cycle |
| in_dc | input | 1 | Qualifier: 0 command, 1 data |
| in_byte | input | 8 | Byte value |
| prog_pulse | input | 1 | Programming pulse from the external programming supply |
| host_cfg | input | 56 | Host-set configuration, 7 bits per byte |
| shadow_q | output | 56 | Raw shadow register contents |
| eff_cfg | output | 56 | Effective configuration after the factory-default select |
| row_sel | output | 3 | Selected row address |
| prog_sw_en | output | 1 | Programming switch enable |
| cal_mode | output | 1 | Calibration-mode flag |
| refresh_busy | output | 1 | A refresh is in progress |

## Verification
The bench sweeps all 32 combinations of the configuration field. Random upper bits ride along with each value, so a decoder that took the flags from the wrong bits, or let bits 7:5 leak through, would show a wrong row or flag. A shift run longer than the chain, with bit 7 set on alternate bytes, catches reversed shift order, a retained top byte or a leaked bit 7. The bench times refresh to the exact cycle, sends a second wake command during a refresh, and sends a wake command in calibration mode. These catch an off-by-one busy window, a refresh that restarts, or a refresh that is not suppressed. Programming pulses are sent with each enable missing, and the results are read back through a refresh. This exposes a design that burns without both flags set or that writes the wrong row.

// File: rtl/otp_pkg.sv
// Shared constants and types for the OTP shadow controller.
// Assumes a fixed 3-bit row address, so the matrix has eight 7-bit rows.
package otp_pkg;
    localparam int ROW_AW    = 3;
    localparam int NUM_ROWS  = 1 << ROW_AW;
    localparam int CELL_BITS = 7;
    localparam int FLAT_W    = NUM_ROWS * CELL_BITS;

    localparam logic [7:0] CMD_CALCTL  = 8'hF0;
    localparam logic [7:0] CMD_SHIFTIN = 8'hF1;
    localparam logic [7:0] CMD_WAKE    = 8'h11;
    localparam logic [7:0] CMD_FDS_CLR = 8'hEE;
    localparam logic [7:0] CMD_FDS_SET = 8'hEF;

    typedef enum logic [1:0] {
        DEC_IDLE  = 2'd0,
        DEC_CFG   = 2'd1,
        DEC_SHIFT = 2'd2
    } dec_state_t;

    typedef struct packed {
        logic [ROW_AW-1:0] row;
        logic              pe;
        logic              cal;
    } cal_ctrl_t;
endpackage

// File: rtl/otp_cmd_decoder.sv
// Decodes the qualified byte stream. It holds the calibration control
// flags and the factory-default select, and emits one-cycle shift and
// refresh requests. Assumes at most one byte per cycle.
module otp_cmd_decoder
    import otp_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic                 in_dc,
    input  logic [7:0]           in_byte,
    output logic                 shift_en,
    output logic [CELL_BITS-1:0] shift_byte,
    output logic                 refresh_req,
    output cal_ctrl_t            ctrl,
    output logic                 fds_sel
);
    dec_state_t state_q;
    cal_ctrl_t  ctrl_q;
    logic       fds_q;
    logic       is_cmd;
    logic       is_data;

    // Classify the incoming byte.
    always_comb begin
        is_cmd  = in_valid && !in_dc;
        is_data = in_valid && in_dc;
    end

    // Command state, control flags and factory-default select.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= DEC_IDLE;
            ctrl_q  <= '0;
            fds_q   <= 1'b1;
        end else if (is_cmd) begin
            case (in_byte)
                CMD_CALCTL:  state_q <= DEC_CFG;
                CMD_SHIFTIN: state_q <= DEC_SHIFT;
                CMD_FDS_CLR: begin state_q <= DEC_IDLE; fds_q <= 1'b0; end
                CMD_FDS_SET: begin state_q <= DEC_IDLE; fds_q <= 1'b1; end
                default:     state_q <= DEC_IDLE;
            endcase
        end else if (is_data && state_q == DEC_CFG) begin
            ctrl_q  <= in_byte[ROW_AW+1:0];
            state_q <= DEC_IDLE;
        end
    end

    // Request strobes toward the matrix and the refresh timer.
    always_comb begin
        shift_en    = is_data && (state_q == DEC_SHIFT);
        shift_byte  = in_byte[CELL_BITS-1:0];
        refresh_req = is_cmd && (in_byte == CMD_WAKE) && !ctrl_q.cal;
        ctrl        = ctrl_q;
        fds_sel     = fds_q;
    end

    assert_cfg_from_data_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ctrl_q) |-> $past(is_data));
    assert_fds_from_cmd_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(fds_q) |-> $past(is_cmd));
endmodule

// File: rtl/otp_refresh_timer.sv
// Background refresh timer. A start request while idle holds busy for
// REFRESH_CYCLES cycles, then pulses done. Requests while busy are
// ignored. Assumes REFRESH_CYCLES >= 1.
module otp_refresh_timer #(
    parameter int REFRESH_CYCLES = 50000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy,
    output logic done
);
    localparam int CNT_W = $clog2(REFRESH_CYCLES + 1);
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(REFRESH_CYCLES - 1);

    logic             busy_q;
    logic [CNT_W-1:0] cnt_q;

    // Completion is the last busy cycle.
    always_comb begin
        done = busy_q && (cnt_q == '0);
        busy = busy_q;
    end

    // Count down while busy; a start arriving during a refresh is dropped.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
        end else if (!busy_q) begin
            if (start) begin
                busy_q <= 1'b1;
                cnt_q  <= CNT_LOAD;
            end
        end else if (done) begin
            busy_q <= 1'b0;
        end else begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assert_busy_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && cnt_q != '0) |=> busy_q);
    assert_busy_ends_R4: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy_q);
    assert_no_retrigger_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && start && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/otp_matrix.sv
// Shadow shift chain plus a behavioural non-volatile array. A refresh
// load takes priority over a shift in the same cycle. A burn ORs the
// selected shadow row into the same array row. The array starts from
// NV_INIT at reset.
module otp_matrix
    import otp_pkg::*;
#(
    parameter logic [FLAT_W-1:0] NV_INIT = '0
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 shift_en,
    input  logic [CELL_BITS-1:0] shift_byte,
    input  logic                 load,
    input  logic                 burn,
    input  logic [ROW_AW-1:0]    burn_row,
    output logic [FLAT_W-1:0]    shadow_flat
);
    logic [CELL_BITS-1:0] shadow_q [NUM_ROWS];
    logic [CELL_BITS-1:0] nv_q     [NUM_ROWS];

    for (genvar g = 0; g < NUM_ROWS; g++) begin : g_row
        // Shadow cell: reload from the array, or take the neighbour on a shift.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                shadow_q[g] <= '0;
            end else if (load) begin
                shadow_q[g] <= nv_q[g];
            end else if (shift_en) begin
                if (g == 0) shadow_q[g] <= shift_byte;
                else        shadow_q[g] <= shadow_q[(g == 0) ? 0 : g-1];
            end
        end

        // Array row: accumulate ones from the shadow on a burn aimed here.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                nv_q[g] <= NV_INIT[g*CELL_BITS +: CELL_BITS];
            end else if (burn && burn_row == ROW_AW'(g)) begin
                nv_q[g] <= nv_q[g] | shadow_q[g];
            end
        end

        // Flatten for the port.
        always_comb shadow_flat[g*CELL_BITS +: CELL_BITS] = shadow_q[g];

        assert_nv_keeps_ones_R9: assert property (@(posedge clk) disable iff (!rst_n)
            1'b1 |=> ((nv_q[g] & $past(nv_q[g])) == $past(nv_q[g])));
    end

    assert_shift_chain_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_en && !load) |=> (shadow_q[1] == $past(shadow_q[0])));
endmodule

// File: rtl/otp_shadow_ctrl.sv
// Top level of the OTP shadow controller. It ties the decoder, the
// refresh timer and the matrix together, gates programming pulses with
// the calibration flags and applies the factory-default select.
// Assumes host_cfg is stable while it is being used.
module otp_shadow_ctrl
    import otp_pkg::*;
#(
    parameter int                REFRESH_CYCLES = 50000,
    parameter int                CAL_IDX        = 0,
    parameter logic [FLAT_W-1:0] NV_INIT        = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              in_dc,
    input  logic [7:0]        in_byte,
    input  logic              prog_pulse,
    input  logic [FLAT_W-1:0] host_cfg,
    output logic [FLAT_W-1:0] shadow_q,
    output logic [FLAT_W-1:0] eff_cfg,
    output logic [ROW_AW-1:0] row_sel,
    output logic              prog_sw_en,
    output logic              cal_mode,
    output logic              refresh_busy
);
    logic                 shift_en;
    logic [CELL_BITS-1:0] shift_byte;
    logic                 refresh_req;
    cal_ctrl_t            ctrl;
    logic                 fds_sel;
    logic                 rf_done;
    logic                 burn;

    otp_cmd_decoder u_dec (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_dc(in_dc),
        .in_byte(in_byte), .shift_en(shift_en), .shift_byte(shift_byte),
        .refresh_req(refresh_req), .ctrl(ctrl), .fds_sel(fds_sel)
    );

    otp_refresh_timer #(.REFRESH_CYCLES(REFRESH_CYCLES)) u_tmr (
        .clk(clk), .rst_n(rst_n), .start(refresh_req),
        .busy(refresh_busy), .done(rf_done)
    );

    otp_matrix #(.NV_INIT(NV_INIT)) u_mtx (
        .clk(clk), .rst_n(rst_n), .shift_en(shift_en), .shift_byte(shift_byte),
        .load(rf_done), .burn(burn), .burn_row(ctrl.row),
        .shadow_flat(shadow_q)
    );

    // Burn qualification and the control outputs.
    always_comb begin
        burn       = prog_pulse && ctrl.cal && ctrl.pe;
        prog_sw_en = ctrl.pe;
        cal_mode   = ctrl.cal;
        row_sel    = ctrl.row;
    end

    // Effective configuration: the calibration byte always comes from the shadows.
    for (genvar g = 0; g < NUM_ROWS; g++) begin : g_eff
        if (g == CAL_IDX) begin : g_cal
            always_comb eff_cfg[g*CELL_BITS +: CELL_BITS] = shadow_q[g*CELL_BITS +: CELL_BITS];
        end else begin : g_other
            always_comb eff_cfg[g*CELL_BITS +: CELL_BITS] =
                fds_sel ? shadow_q[g*CELL_BITS +: CELL_BITS] : host_cfg[g*CELL_BITS +: CELL_BITS];
        end
    end

    assert_no_refresh_in_cal_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(refresh_busy) |-> !$past(cal_mode));
    assert_switch_follows_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(prog_sw_en) |-> $past(in_valid && in_dc));
endmodule

// File: tb/test_otp_shadow_ctrl.sv
module test_otp_shadow_ctrl;
    localparam int RC  = 6;
    localparam int CI  = 0;
    localparam int NR  = 8;
    localparam int FW  = 56;
    localparam logic [FW-1:0] NVI = 56'h1A_2B3C_4D5E_6F70;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic          in_dc = 1'b0;
    logic [7:0]    in_byte = 8'h00;
    logic          prog_pulse = 1'b0;
    logic [FW-1:0] host_cfg = '0;
    logic [FW-1:0] shadow_q, eff_cfg;
    logic [2:0]    row_sel;
    logic          prog_sw_en, cal_mode, refresh_busy;

    int errors = 0;
    int checks = 0;
    bit ended  = 1'b0;

    logic [6:0] nvm [NR];
    logic [6:0] shm [NR];

    always #10 clk = ~clk;

    otp_shadow_ctrl #(.REFRESH_CYCLES(RC), .CAL_IDX(CI), .NV_INIT(NVI)) i_otp_shadow_ctrl (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_dc(in_dc), .in_byte(in_byte),
        .prog_pulse(prog_pulse), .host_cfg(host_cfg), .shadow_q(shadow_q), .eff_cfg(eff_cfg),
        .row_sel(row_sel), .prog_sw_en(prog_sw_en), .cal_mode(cal_mode),
        .refresh_busy(refresh_busy)
    );

    function automatic logic [FW-1:0] flat_sh();
        logic [FW-1:0] v;
        for (int i = 0; i < NR; i++) v[i*7 +: 7] = shm[i];
        return v;
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    // Present one byte for exactly one capturing edge.
    task automatic send(input logic dc, input logic [7:0] b);
        in_valid = 1'b1; in_dc = dc; in_byte = b;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic set_ctrl(input logic [7:0] b);
        send(1'b0, 8'hF0);
        send(1'b1, b);
    endtask

    task automatic pulse();
        prog_pulse = 1'b1;
        step();
        prog_pulse = 1'b0;
    endtask

    task automatic finish_up();
        if (!ended) begin
            ended = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_up();
    end

    initial begin
        for (int i = 0; i < NR; i++) begin nvm[i] = NVI[i*7 +: 7]; shm[i] = '0; end
        repeat (3) step();
        rst_n = 1'b1;
        step();
        // R1 reset state
        chk("R1 shadow", shadow_q, '0);
        chk("R1 eff", eff_cfg, '0);
        chk("R1 row", row_sel, 0);
        chk("R1 flags", {prog_sw_en, cal_mode, refresh_busy}, 0);

        // R4 refresh timing
        send(1'b0, 8'h11);
        chk("R4 busy start", refresh_busy, 1);
        repeat (RC-1) step();
        chk("R4 busy before end", {refresh_busy, shadow_q}, {1'b1, 56'h0});
        step();
        for (int i = 0; i < NR; i++) shm[i] = nvm[i];
        chk("R4 busy end", refresh_busy, 0);
        chk("R4 shadow loaded", shadow_q, flat_sh());

        // R12 second wake during refresh
        send(1'b0, 8'h11);
        send(1'b0, 8'h11);
        repeat (RC-2) step();
        chk("R12 still busy", refresh_busy, 1);
        step();
        chk("R12 ends on time", refresh_busy, 0);

        // R7 shift sweep, longer than the chain, bit 7 toggled
        send(1'b0, 8'hF1);
        for (int i = 0; i < 12; i++) begin
            logic [7:0] b;
            b = 8'((i*37 + 5) & 8'h7F) | ((i % 2) ? 8'h80 : 8'h00);
            send(1'b1, b);
            for (int j = NR-1; j > 0; j--) shm[j] = shm[j-1];
            shm[0] = b[6:0];
            chk("R7 shift", shadow_q, flat_sh());
        end

        // R8 command ends shifting
        send(1'b0, 8'h00);
        send(1'b1, 8'h55);
        chk("R8 no shift after cmd", shadow_q, flat_sh());

        // R11 stray data and unknown commands
        send(1'b1, 8'h7F);
        send(1'b0, 8'h3C);
        send(1'b1, 8'h1F);
        chk("R11 shadow untouched", shadow_q, flat_sh());
        chk("R11 flags untouched", {row_sel, prog_sw_en, cal_mode, refresh_busy}, 0);
        send(1'b0, 8'hF0);
        send(1'b0, 8'h00);
        send(1'b1, 8'h1F);
        chk("R11 armed load cancelled", {row_sel, prog_sw_en, cal_mode}, 0);

        // R2 / R3 sweep of the configuration field
        for (int v = 0; v < 32; v++) begin
            logic [7:0] b;
            b = {3'(v*3 + 1), 5'(v)};
            set_ctrl(b);
            chk("R2 row", row_sel, 64'(v >> 2));
            chk("R2 cal", cal_mode, 64'(v & 1));
            chk("R3 switch", prog_sw_en, 64'((v >> 1) & 1));
        end

        // R5 wake in calibration mode
        set_ctrl(8'h01);
        send(1'b0, 8'h11);
        chk("R5 no busy", refresh_busy, 0);
        repeat (RC+1) step();
        chk("R5 shadow unchanged", {refresh_busy, shadow_q}, {1'b0, flat_sh()});

        // R9 burn qualification
        set_ctrl({3'b000, 3'd2, 1'b0, 1'b1});   // cal=1, pe=0, row 2
        pulse();
        set_ctrl({3'b000, 3'd3, 1'b1, 1'b1});   // cal=1, pe=1, row 3
        pulse();
        nvm[3] = nvm[3] | shm[3];
        set_ctrl({3'b000, 3'd6, 1'b1, 1'b0});   // cal=0, pe=1, row 6
        pulse();
        set_ctrl(8'h00);
        send(1'b0, 8'h11);
        repeat (RC) step();
        for (int i = 0; i < NR; i++) shm[i] = nvm[i];
        chk("R9 array after burns", shadow_q, flat_sh());

        // R6 commands accepted during refresh
        send(1'b0, 8'h11);
        set_ctrl(8'h16);                        // row 5, pe=1, cal=0
        chk("R6 busy while cfg", refresh_busy, 1);
        chk("R6 cfg applied", {row_sel, prog_sw_en, cal_mode}, {3'd5, 1'b1, 1'b0});
        repeat (RC) step();
        chk("R6 refresh completed", {refresh_busy, shadow_q}, {1'b0, flat_sh()});

        // R10 factory-default select
        host_cfg = 56'hF0_E1D2_C3B4_A596;
        chk("R10 select set", eff_cfg, shadow_q);
        send(1'b0, 8'hEE);
        begin
            logic [FW-1:0] e;
            for (int i = 0; i < NR; i++)
                e[i*7 +: 7] = (i == CI) ? shm[i] : host_cfg[i*7 +: 7];
            chk("R10 select clear", eff_cfg, e);
        end
        send(1'b0, 8'hEF);
        chk("R10 select set again", eff_cfg, flat_sh());

        finish_up();
    end
endmodule